// File: doc/BRIEF.md
# Fused Three-Operand Cipher ALU

This is a 32-bit execution unit for cipher kernels. Each instruction carries three source operands and produces at most one result. Within a single cycle it runs two dependent operations drawn from two classes. The "tiny" class holds cheap logic and unary steps. The "short" class holds add, subtract and the rotates. Chaining a logical step onto an arithmetic one inside the same instruction removes the trailing XOR that usually sits on a cipher round's critical path.

A two-bit pair selector sets the chaining. In short-then-tiny order, the short operation combines operands 1 and 2, and the tiny operation then merges that value with operand 3. In tiny-then-short order the roles swap. Tiny-then-tiny chains two logical steps the same way. A fourth selector value runs a multiply-class operation on its own, with the second slot required to be nop.

The result, a valid strobe and an illegal-op flag are registered, so a result appears one clock after the instruction is accepted. A pair that is not in the legal set sets the flag and leaves the result register untouched.

Top module: `fused_cipher_alu`

## Requirements
- R1: While and directly after synchronous reset, `res_valid`, `illegal` and `res_data` are all 0.
- R2: An instruction with `in_valid` high produces exactly one of `res_valid` or `illegal` on the next cycle. A cycle with `in_valid` low produces neither, and `res_data` holds its value.
- R3: Pair selector 0 (short then tiny): the result is tiny(short(op1, op2), op3). The short code is taken from `first_op` and the tiny code from `second_op`.
- R4: Pair selector 1 (tiny then short): the result is short(tiny(op1, op2), op3). The tiny code is taken from `first_op` and the short code from `second_op`.
- R5: Pair selector 2 (tiny then tiny): the result is tiny2(tiny1(op1, op2), op3). The first tiny code is `first_op` and the second is `second_op`.
- R6: Short code 1 is add and code 2 is subtract (first minus second). Both wrap modulo 2^32.
- R7: Short code 3 rotates the first input left and code 4 rotates it right. The amount is the low 5 bits of the second input.
- R8: Tiny code 1 is XOR and code 2 is AND. Code 3 adds 1 to the first input and ignores the second input. Code 4 sign-extends the low byte of the first input to 32 bits.
- R9: Code 0 in either class is nop and passes its first input through unchanged.
- R10: Pair selector 3 with `second_op` 0 runs a long op. `first_op` 0 gives the low 32 bits of op1*op2, and `first_op` 1 gives (op1*op2) mod 0x10001.
- R11: Any code outside the lists above raises `illegal` with `res_valid` low and leaves `res_data` unchanged. This covers tiny codes 5-7, short codes 5-7 (5 being the table lookup, which this unit does not serve), long codes 2-7, and a nonzero `second_op` on a long pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| pair_sel | input | 2 | Pair kind: 0 short-tiny, 1 tiny-short, 2 tiny-tiny, 3 long |
| first_op | input | 3 | Code of the operation applied to op1 and op2 |
| second_op | input | 3 | Code of the operation applied to the first result and op3 |
| op1 | input | 32 | Source operand 1 |
| op2 | input | 32 | Source operand 2 |
| op3 | input | 32 | Source operand 3 |
| res_valid | output | 1 | Result written this cycle |
| res_data | output | 32 | Registered result |
| illegal | output | 1 | Illegal pair reported this cycle |

## Verification
The bench builds the unit with WIDTH 32 and an 8-bit sign-extend field, which are the defaults. At these sizes the 5-bit rotate mask can be tested with amounts of 32 and above. A 32-bit sum can be driven across its wrap point. The mulmod result is checked against an independent 64-bit product. Every illegal code path is driven against a known held result value, so a stray write becomes visible at `res_data`.

// File: rtl/cipher_alu_pkg.sv
package cipher_alu_pkg;

  typedef enum logic [1:0] {
    PAIR_SHORT_TINY = 2'd0,
    PAIR_TINY_SHORT = 2'd1,
    PAIR_TINY_TINY  = 2'd2,
    PAIR_LONG       = 2'd3
  } pair_e;

  typedef enum logic [2:0] {
    TINY_NOP  = 3'd0,
    TINY_XOR  = 3'd1,
    TINY_AND  = 3'd2,
    TINY_INC  = 3'd3,
    TINY_SEXT = 3'd4
  } tiny_e;

  typedef enum logic [2:0] {
    SHORT_NOP = 3'd0,
    SHORT_ADD = 3'd1,
    SHORT_SUB = 3'd2,
    SHORT_ROL = 3'd3,
    SHORT_ROR = 3'd4
  } short_e;

  typedef enum logic [2:0] {
    LONG_MUL    = 3'd0,
    LONG_MULMOD = 3'd1
  } long_e;

endpackage

// File: rtl/cipher_tiny_unit.sv
module cipher_tiny_unit #(
  parameter int WIDTH  = 32,
  parameter int SEXT_W = 8
) (
  input  logic [2:0]       code,
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  output logic [WIDTH-1:0] r,
  output logic             ok
);
  import cipher_alu_pkg::*;

  localparam int PAD_W = WIDTH - SEXT_W;

  logic [WIDTH-1:0] sext_v;
  assign sext_v = {{PAD_W{x[SEXT_W-1]}}, x[SEXT_W-1:0]};

  always_comb begin
    ok = 1'b1;
    r  = x;
    case (code)
      TINY_NOP:  r = x;
      TINY_XOR:  r = x ^ y;
      TINY_AND:  r = x & y;
      TINY_INC:  r = x + WIDTH'(1);
      TINY_SEXT: r = sext_v;
      default: begin
        r  = x;
        ok = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/cipher_short_unit.sv
module cipher_short_unit #(
  parameter int WIDTH = 32
) (
  input  logic [2:0]       code,
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  output logic [WIDTH-1:0] r,
  output logic             ok
);
  import cipher_alu_pkg::*;

  localparam int SHW = $clog2(WIDTH);

  logic [SHW-1:0]     amt;
  logic [2*WIDTH-1:0] dbl_l, dbl_r;

  assign amt   = y[SHW-1:0];
  assign dbl_l = {x, x} << amt;
  assign dbl_r = {x, x} >> amt;

  always_comb begin
    ok = 1'b1;
    r  = x;
    case (code)
      SHORT_NOP: r = x;
      SHORT_ADD: r = x + y;
      SHORT_SUB: r = x - y;
      SHORT_ROL: r = dbl_l[2*WIDTH-1:WIDTH];
      SHORT_ROR: r = dbl_r[WIDTH-1:0];
      default: begin
        r  = x;
        ok = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/cipher_long_unit.sv
module cipher_long_unit #(
  parameter int WIDTH    = 32,
  parameter int LONG_MOD = 65537
) (
  input  logic [2:0]       code,
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  output logic [WIDTH-1:0] r,
  output logic             ok
);
  import cipher_alu_pkg::*;

  localparam int PW = 2 * WIDTH;

  logic [PW-1:0] prod;
  logic [PW-1:0] rem;

  assign prod = PW'(x) * PW'(y);
  assign rem  = prod % PW'(LONG_MOD);

  always_comb begin
    ok = 1'b1;
    r  = prod[WIDTH-1:0];
    case (code)
      LONG_MUL:    r = prod[WIDTH-1:0];
      LONG_MULMOD: r = rem[WIDTH-1:0];
      default: begin
        r  = prod[WIDTH-1:0];
        ok = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/fused_cipher_alu.sv
module fused_cipher_alu #(
  parameter int WIDTH    = 32,
  parameter int SEXT_W   = 8,
  parameter int LONG_MOD = 65537
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       pair_sel,
  input  logic [2:0]       first_op,
  input  logic [2:0]       second_op,
  input  logic [WIDTH-1:0] op1,
  input  logic [WIDTH-1:0] op2,
  input  logic [WIDTH-1:0] op3,
  output logic             res_valid,
  output logic [WIDTH-1:0] res_data,
  output logic             illegal
);
  import cipher_alu_pkg::*;

  pair_e pair;
  assign pair = pair_e'(pair_sel);

  logic             short_first;
  logic [2:0]       short_code;
  logic [WIDTH-1:0] short_x, short_y, short_r;
  logic             short_ok;
  logic [WIDTH-1:0] tiny1_r, tiny2_x, tiny2_r, long_r;
  logic             tiny1_ok, tiny2_ok, long_ok;

  assign short_first = (pair == PAIR_SHORT_TINY);
  assign short_code  = short_first ? first_op : second_op;
  assign short_x     = short_first ? op1 : tiny1_r;
  assign short_y     = short_first ? op2 : op3;
  assign tiny2_x     = short_first ? short_r : tiny1_r;

  cipher_tiny_unit #(.WIDTH(WIDTH), .SEXT_W(SEXT_W)) u_tiny1 (
    .code(first_op), .x(op1), .y(op2), .r(tiny1_r), .ok(tiny1_ok)
  );

  cipher_short_unit #(.WIDTH(WIDTH)) u_short (
    .code(short_code), .x(short_x), .y(short_y), .r(short_r), .ok(short_ok)
  );

  cipher_tiny_unit #(.WIDTH(WIDTH), .SEXT_W(SEXT_W)) u_tiny2 (
    .code(second_op), .x(tiny2_x), .y(op3), .r(tiny2_r), .ok(tiny2_ok)
  );

  cipher_long_unit #(.WIDTH(WIDTH), .LONG_MOD(LONG_MOD)) u_long (
    .code(first_op), .x(op1), .y(op2), .r(long_r), .ok(long_ok)
  );

  logic [WIDTH-1:0] sel_r;
  logic             sel_ok;

  always_comb begin
    case (pair)
      PAIR_SHORT_TINY: begin sel_r = tiny2_r; sel_ok = short_ok & tiny2_ok; end
      PAIR_TINY_SHORT: begin sel_r = short_r; sel_ok = tiny1_ok & short_ok; end
      PAIR_TINY_TINY:  begin sel_r = tiny2_r; sel_ok = tiny1_ok & tiny2_ok; end
      default:         begin sel_r = long_r;  sel_ok = long_ok & (second_op == 3'd0); end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      illegal   <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= in_valid & sel_ok;
      illegal   <= in_valid & ~sel_ok;
      if (in_valid && sel_ok) res_data <= sel_r;
    end
  end
endmodule

// File: rtl/cipher_alu_checker.sv
module cipher_alu_checker #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             res_valid,
  input logic             illegal,
  input logic [WIDTH-1:0] res_data
);
  AST_RESET_QUIET: assert property (@(posedge clk) $past(rst) |-> (!res_valid && !illegal && res_data == '0)); // R1
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst) !(res_valid && illegal)); // R2
  AST_ANSWER_EACH: assert property (@(posedge clk) disable iff (rst) $past(in_valid) |-> (res_valid || illegal)); // R2
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst) !$past(in_valid) |-> (!res_valid && !illegal)); // R2
  AST_IDLE_HOLDS:  assert property (@(posedge clk) disable iff (rst) (!res_valid && !$past(rst)) |-> $stable(res_data)); // R2
  AST_ILLEGAL_NOWRITE: assert property (@(posedge clk) disable iff (rst) (illegal && !$past(rst)) |-> $stable(res_data)); // R11
endmodule

bind fused_cipher_alu cipher_alu_checker #(.WIDTH(WIDTH)) u_checker (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .res_valid(res_valid), .illegal(illegal), .res_data(res_data)
);

// File: tb/tb_fused_cipher_alu.sv
`timescale 1ns/1ps
module tb_fused_cipher_alu;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [1:0] pair_sel = '0;
  logic [2:0] first_op = '0, second_op = '0;
  logic [W-1:0] op1 = '0, op2 = '0, op3 = '0;
  logic res_valid, illegal;
  logic [W-1:0] res_data;

  always #2.5 clk = ~clk;

  fused_cipher_alu #(.WIDTH(W), .SEXT_W(8), .LONG_MOD(65537)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .pair_sel(pair_sel),
    .first_op(first_op), .second_op(second_op), .op1(op1), .op2(op2), .op3(op3),
    .res_valid(res_valid), .res_data(res_data), .illegal(illegal)
  );

  typedef struct {
    logic         v;
    logic         ill;
    logic [W-1:0] d;
    string        tag;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  logic [W-1:0] last_d = '0;
  bit mon_on = 1'b0;

  // reference tiny op: {ok, value}
  function automatic logic [W:0] m_tiny(input logic [2:0] c, input logic [W-1:0] x, input logic [W-1:0] y);
    case (c)
      3'd0: return {1'b1, x};
      3'd1: return {1'b1, x ^ y};
      3'd2: return {1'b1, x & y};
      3'd3: return {1'b1, x + 32'd1};
      3'd4: return {1'b1, {{24{x[7]}}, x[7:0]}};
      default: return {1'b0, x};
    endcase
  endfunction

  function automatic logic [W:0] m_short(input logic [2:0] c, input logic [W-1:0] x, input logic [W-1:0] y);
    int s;
    s = int'(y[4:0]);
    case (c)
      3'd0: return {1'b1, x};
      3'd1: return {1'b1, x + y};
      3'd2: return {1'b1, x - y};
      3'd3: return {1'b1, (s == 0) ? x : ((x << s) | (x >> (32 - s)))};
      3'd4: return {1'b1, (s == 0) ? x : ((x >> s) | (x << (32 - s)))};
      default: return {1'b0, x};
    endcase
  endfunction

  task automatic issue(input logic [1:0] p, input logic [2:0] f, input logic [2:0] s,
                       input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c,
                       input string tag);
    logic [W:0] t1, t2;
    longint unsigned pr;
    exp_t e;
    case (p)
      2'd0: begin t1 = m_short(f, a, b); t2 = m_tiny(s, t1[W-1:0], c); end
      2'd1: begin t1 = m_tiny(f, a, b);  t2 = m_short(s, t1[W-1:0], c); end
      2'd2: begin t1 = m_tiny(f, a, b);  t2 = m_tiny(s, t1[W-1:0], c); end
      default: begin
        pr = longint'(a) * longint'(b);
        t1 = {(s == 3'd0), 32'd0};
        if (f == 3'd0)      t2 = {1'b1, pr[31:0]};
        else if (f == 3'd1) t2 = {1'b1, 32'(pr % 64'd65537)};
        else                t2 = {1'b0, 32'd0};
      end
    endcase
    @(negedge clk);
    in_valid = 1'b1; pair_sel = p; first_op = f; second_op = s;
    op1 = a; op2 = b; op3 = c;
    e.tag = tag;
    if (t1[W] && t2[W]) begin
      e.v = 1'b1; e.ill = 1'b0; e.d = t2[W-1:0]; last_d = t2[W-1:0];
    end else begin
      e.v = 1'b0; e.ill = 1'b1; e.d = last_d;
    end
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b0;
    op1 = 32'hDEAD_BEEF;
    e.v = 1'b0; e.ill = 1'b0; e.d = last_d; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // monitor: pops one expected item per cycle after each capturing edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (mon_on && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check({e.tag, " valid"},   {31'd0, res_valid}, {31'd0, e.v});
        check({e.tag, " illegal"}, {31'd0, illegal},   {31'd0, e.ill});
        check({e.tag, " data"},    res_data,           e.d);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset valid",   {31'd0, res_valid}, 32'd0);
    check("R1 reset illegal", {31'd0, illegal},   32'd0);
    check("R1 reset data",    res_data,           32'd0);
    @(negedge clk);
    rst = 1'b0;
    mon_on = 1'b1;

    idle("R2 idle after reset");
    // R3 short then tiny
    issue(2'd0, 3'd1, 3'd1, 32'h1234_5678, 32'h1111_1111, 32'h0F0F_0F0F, "R3 add-xor");
    issue(2'd0, 3'd2, 3'd2, 32'h0000_1000, 32'h0000_0001, 32'h0000_0F0F, "R3 sub-and");
    // R4 tiny then short
    issue(2'd1, 3'd2, 3'd3, 32'h8000_0001, 32'hFFFF_FFFF, 32'd33, "R4 R7 and-rol mask");
    issue(2'd1, 3'd1, 3'd4, 32'h0000_00F0, 32'h0000_000F, 32'd4, "R4 xor-ror");
    // R5 tiny then tiny
    issue(2'd2, 3'd2, 3'd1, 32'hFF00_FF00, 32'h0FF0_0FF0, 32'hAAAA_AAAA, "R5 and-xor");
    issue(2'd2, 3'd1, 3'd3, 32'h0000_0005, 32'h0000_0003, 32'hFFFF_0000, "R5 R8 xor-inc");
    // R6 wrap
    issue(2'd0, 3'd1, 3'd0, 32'hFFFF_FFFF, 32'd2, 32'h0, "R6 add wrap");
    issue(2'd0, 3'd2, 3'd0, 32'h0, 32'd1, 32'h0, "R6 sub wrap");
    // R7 rotates
    issue(2'd1, 3'd0, 3'd4, 32'h0000_0001, 32'h0, 32'd31, "R7 ror 31");
    issue(2'd1, 3'd0, 3'd4, 32'hCAFE_F00D, 32'h0, 32'd32, "R7 ror by 0");
    issue(2'd1, 3'd0, 3'd3, 32'hF000_0000, 32'h0, 32'd4, "R7 rol 4");
    // R8 inc and sign-extend
    issue(2'd2, 3'd3, 3'd0, 32'hFFFF_FFFF, 32'h1234_5678, 32'h0, "R8 inc ignores op2");
    issue(2'd2, 3'd4, 3'd0, 32'h1234_5680, 32'h0, 32'h0, "R8 sext negative");
    issue(2'd2, 3'd4, 3'd0, 32'hFFFF_FF7F, 32'h0, 32'h0, "R8 sext positive");
    // R9 nop pass-through
    issue(2'd2, 3'd0, 3'd0, 32'h5A5A_1234, 32'h1, 32'h2, "R9 nop-nop");
    issue(2'd0, 3'd0, 3'd1, 32'h0000_FFFF, 32'h7, 32'hFFFF_0000, "R9 nop-xor");
    // R10 long ops
    issue(2'd3, 3'd0, 3'd0, 32'h0001_0003, 32'h0002_0005, 32'h0, "R10 mul");
    issue(2'd3, 3'd1, 3'd0, 32'hFFFF_FFFF, 32'h1234_5678, 32'h0, "R10 mulmod");
    // R11 illegal codes leave data held
    issue(2'd2, 3'd5, 3'd0, 32'h1, 32'h1, 32'h1, "R11 tiny code 5");
    issue(2'd0, 3'd5, 3'd1, 32'h1, 32'h1, 32'h1, "R11 lookup code");
    issue(2'd1, 3'd1, 3'd7, 32'h1, 32'h1, 32'h1, "R11 short code 7");
    issue(2'd3, 3'd0, 3'd1, 32'h3, 32'h3, 32'h0, "R11 long with second op");
    issue(2'd3, 3'd2, 3'd0, 32'h3, 32'h3, 32'h0, "R11 long code 2");
    idle("R2 idle hold");
    issue(2'd0, 3'd1, 3'd1, 32'h10, 32'h20, 32'h0, "R2 back to back");

    for (int i = 0; i < 40; i++) begin
      logic [1:0] p;
      logic [2:0] f, s;
      p = 2'($urandom_range(0, 3));
      case (p)
        2'd0: begin f = 3'($urandom_range(0, 4)); s = 3'($urandom_range(0, 4)); end
        2'd1: begin f = 3'($urandom_range(0, 4)); s = 3'($urandom_range(0, 4)); end
        2'd2: begin f = 3'($urandom_range(0, 4)); s = 3'($urandom_range(0, 4)); end
        default: begin f = 3'($urandom_range(0, 1)); s = 3'd0; end
      endcase
      issue(p, f, s, $urandom, $urandom, $urandom, "R3 R4 R5 R10 mixed");
    end
    idle("R2 drain");

    while (q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule